// File: doc/BRIEF.md
# PCI Express Lane Receiver-Presence Detection Sequencer

This block runs the far-end receiver presence test for one transmit lane of a PCI Express PHY. The MAC raises a detect request while the lane is in the P1 low-power state with the driver held in electrical idle. The block then asks the analog front end to step the transmitter common-mode level. It counts the cycles until a digitized comparator input reports that the output has settled past its threshold.

A compliant receiver at the far end loads the line, so the step settles slowly. An open or powered-down far end lets it settle quickly. The block compares the measured settling count with a threshold set by a parameter. It answers with a one-cycle done pulse and a 3-bit status code on that same cycle. If the comparator never crosses, a timeout ends the measurement and the result is treated as a receiver being present.

Requests that arrive too early are held back until two conditions are met: the lane is in P1, and electrical idle has been forced for long enough. Each detection needs a fresh rising request.

Top module: `rxdet_seq`

## Requirements
- R1: After synchronous reset, `step_en`, `done` and `drv_tristate` are low and `status` is 3'b000.
- R2: A detection starts only on a clock edge where `pwr_state` equals 2'b10 (P1). A request made in P0 (2'b00), P0s (2'b01) or P2 (2'b11) is held off, and it starts on the first edge at which the lane is in P1.
- R3: A detection starts only once `force_idle` has been sampled high on at least IDLE_LEAD consecutive clock edges before the start edge. Any edge with `force_idle` low restarts that count from zero.
- R4: `step_en` rises in the cycle after the start edge and stays high until the cycle in which `done` is high. In that cycle it is low.
- R5: The settling count is the number of edges with `cmp_level` low between the rise of `step_en` and the first edge that samples `cmp_level` high. `done` is high in the cycle after that edge.
- R6: On `done`, `status` is 3'b011 (receiver present) when the settling count is at least PRESENT_THR, and 3'b000 (no receiver) otherwise.
- R7: If `cmp_level` stays low for TIMEOUT edges after `step_en` rises, `done` is issued in the following cycle with status 3'b011.
- R8: `done` is high for exactly one cycle per detection, and `status` is 3'b000 in every cycle where `done` is low.
- R9: A request that stays high after its detection, or that was already high when reset was released, starts nothing. A new detection needs `det_req` to be sampled low and then high again.
- R10: `drv_tristate` is high in every cycle following an edge at which `force_idle` was high. It also stays high for the whole time `step_en` is high, even if `force_idle` drops during the measurement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parallel-domain clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_state | input | 2 | Lane power state: 00 P0, 01 P0s, 10 P1, 11 P2 |
| force_idle | input | 1 | MAC forces transmitter electrical idle |
| det_req | input | 1 | MAC request for receiver detection |
| cmp_level | input | 1 | Digitized comparator: high once the stepped output has crossed its threshold |
| drv_tristate | output | 1 | Tri-state enable to the transmit driver |
| step_en | output | 1 | Common-mode step request to the analog front end |
| done | output | 1 | One-cycle completion pulse |
| status | output | 3 | Result code, valid only while `done` is high |

## Verification
The hardest situation to reach from the ports is a comparator crossing that lands exactly on the present/absent boundary or on the timeout boundary. The difference there is one cycle of settling time. The bench models the analog step as a comparator edge delayed by a chosen number of cycles after `step_en` is seen. It sweeps that delay over every value from zero to past the timeout. For each delay it predicts the done cycle and the status code arithmetically. The other hard case is the electrical-idle lead count restarting partway through a held-off request. The bench reaches it by dropping `force_idle` for a single cycle after several qualifying cycles. It then checks that the start moves out by a full lead period.

// File: rtl/rxdet_pkg.sv
package rxdet_pkg;
  localparam logic [1:0] PWR_P0  = 2'b00;
  localparam logic [1:0] PWR_P0S = 2'b01;
  localparam logic [1:0] PWR_P1  = 2'b10;
  localparam logic [1:0] PWR_P2  = 2'b11;

  localparam logic [2:0] ST_NONE  = 3'b000;
  localparam logic [2:0] ST_FOUND = 3'b011;

  typedef enum logic [0:0] {
    SQ_IDLE    = 1'b0,
    SQ_MEASURE = 1'b1
  } seq_state_t;
endpackage

// File: rtl/rxdet_lead_qual.sv
module rxdet_lead_qual #(
  parameter int IDLE_LEAD = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic force_idle,
  output logic lead_ok
);
  localparam int LW = $clog2(IDLE_LEAD + 1);
  localparam logic [LW-1:0] LEAD_V = LW'(IDLE_LEAD);

  logic [LW-1:0] idle_cnt;

  always_ff @(posedge clk) begin
    if (rst || !force_idle) idle_cnt <= '0;
    else if (idle_cnt != LEAD_V) idle_cnt <= idle_cnt + 1'b1;
  end

  assign lead_ok = (idle_cnt == LEAD_V);

  assert_lead_restart_R3: assert property (@(posedge clk) disable iff (rst)
    !force_idle |=> !lead_ok);
  assert_lead_bound_R3: assert property (@(posedge clk) disable iff (rst)
    idle_cnt <= LEAD_V);
endmodule

// File: rtl/rxdet_settle_timer.sv
module rxdet_settle_timer #(
  parameter int TIMEOUT = 64
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         run,
  input  logic                         cmp_level,
  output logic                         hit,
  output logic                         expire,
  output logic [$clog2(TIMEOUT+1)-1:0] count
);
  localparam int CW = $clog2(TIMEOUT + 1);
  localparam logic [CW-1:0] LAST_V = CW'(TIMEOUT - 1);

  always_ff @(posedge clk) begin
    if (rst || !run) count <= '0;
    else if (!hit && !expire) count <= count + 1'b1;
  end

  assign hit    = run && cmp_level;
  assign expire = run && !cmp_level && (count == LAST_V);

  assert_count_bound_R7: assert property (@(posedge clk) disable iff (rst)
    count <= LAST_V);
endmodule

// File: rtl/rxdet_seq_fsm.sv
module rxdet_seq_fsm
  import rxdet_pkg::*;
#(
  parameter int TIMEOUT     = 64,
  parameter int PRESENT_THR = 16
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [1:0]                   pwr_state,
  input  logic                         force_idle,
  input  logic                         det_req,
  input  logic                         lead_ok,
  input  logic                         hit,
  input  logic                         expire,
  input  logic [$clog2(TIMEOUT+1)-1:0] count,
  output logic                         run,
  output logic                         drv_tristate,
  output logic                         step_en,
  output logic                         done,
  output logic [2:0]                   status
);
  localparam int CW = $clog2(TIMEOUT + 1);
  localparam logic [CW-1:0] THR_V = CW'(PRESENT_THR);

  seq_state_t state;
  logic armed, start, finish, present, step_nxt;

  assign start    = (state == SQ_IDLE) && armed && det_req &&
                    (pwr_state == PWR_P1) && lead_ok;
  assign finish   = (state == SQ_MEASURE) && (hit || expire);
  assign present  = expire || (count >= THR_V);
  assign step_nxt = start || ((state == SQ_MEASURE) && !finish);
  assign run      = (state == SQ_MEASURE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= SQ_IDLE;
      armed        <= 1'b0;
      step_en      <= 1'b0;
      drv_tristate <= 1'b0;
      done         <= 1'b0;
      status       <= ST_NONE;
    end else begin
      step_en      <= step_nxt;
      drv_tristate <= force_idle || step_nxt;
      done         <= finish;
      status       <= (finish && present) ? ST_FOUND : ST_NONE;
      if (!det_req)   armed <= 1'b1;
      else if (start) armed <= 1'b0;
      if (start)       state <= SQ_MEASURE;
      else if (finish) state <= SQ_IDLE;
    end
  end

  assert_start_in_p1_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(step_en) |-> $past(pwr_state) == PWR_P1);
  assert_start_after_lead_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(step_en) |-> $past(lead_ok));
  assert_done_ends_step_R4: assert property (@(posedge clk) disable iff (rst)
    done |-> !step_en && $past(step_en));
  assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_status_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    !done |-> status == ST_NONE);
  assert_status_code_R6: assert property (@(posedge clk) disable iff (rst)
    done |-> (status == ST_NONE || status == ST_FOUND));
endmodule

// File: rtl/rxdet_seq.sv
module rxdet_seq #(
  parameter int IDLE_LEAD   = 10,
  parameter int PRESENT_THR = 16,
  parameter int TIMEOUT     = 64
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] pwr_state,
  input  logic       force_idle,
  input  logic       det_req,
  input  logic       cmp_level,
  output logic       drv_tristate,
  output logic       step_en,
  output logic       done,
  output logic [2:0] status
);
  localparam int CW = $clog2(TIMEOUT + 1);

  logic          lead_ok, run, hit, expire;
  logic [CW-1:0] count;

  rxdet_lead_qual #(.IDLE_LEAD(IDLE_LEAD)) u_lead (
    .clk(clk), .rst(rst), .force_idle(force_idle), .lead_ok(lead_ok)
  );

  rxdet_settle_timer #(.TIMEOUT(TIMEOUT)) u_timer (
    .clk(clk), .rst(rst), .run(run), .cmp_level(cmp_level),
    .hit(hit), .expire(expire), .count(count)
  );

  rxdet_seq_fsm #(.TIMEOUT(TIMEOUT), .PRESENT_THR(PRESENT_THR)) u_fsm (
    .clk(clk), .rst(rst), .pwr_state(pwr_state), .force_idle(force_idle),
    .det_req(det_req), .lead_ok(lead_ok), .hit(hit), .expire(expire),
    .count(count), .run(run), .drv_tristate(drv_tristate),
    .step_en(step_en), .done(done), .status(status)
  );

  assert_step_tristate_R10: assert property (@(posedge clk) disable iff (rst)
    step_en |-> drv_tristate);
  assert_idle_tristate_R10: assert property (@(posedge clk) disable iff (rst)
    force_idle |=> drv_tristate);
endmodule

// File: tb/rxdet_seq_bench.sv
module rxdet_seq_bench;
  localparam int LEAD = 10;
  localparam int THR  = 6;
  localparam int TO   = 12;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] pwr_state = 2'b10;
  logic       force_idle = 1'b0;
  logic       det_req = 1'b0;
  logic       cmp_level = 1'b0;
  logic       drv_tristate, step_en, done;
  logic [2:0] status;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit ended  = 0;

  rxdet_seq #(.IDLE_LEAD(LEAD), .PRESENT_THR(THR), .TIMEOUT(TO)) u_rxdet_seq (
    .clk(clk), .rst(rst), .pwr_state(pwr_state), .force_idle(force_idle),
    .det_req(det_req), .cmp_level(cmp_level), .drv_tristate(drv_tristate),
    .step_en(step_en), .done(done), .status(status)
  );

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Drive cmp high d cycles after step_en is observed; check timing and result.
  task automatic measure(input int d, input bit drop_idle);
    int exp_n, meas;
    logic [2:0] exp_st;
    meas   = (d < TO) ? d : TO - 1;
    exp_n  = meas + 1;
    exp_st = (d >= TO || meas >= THR) ? 3'b011 : 3'b000;
    chk(step_en === 1'b1, "R4 step rise", int'(step_en), 1);
    if (drop_idle) force_idle = 1'b0;
    for (int n = 0; n < exp_n; n++) begin
      if (n == d) cmp_level = 1'b1;
      @(negedge clk);
      if (n + 1 == exp_n) begin
        chk(done === 1'b1, (d >= TO) ? "R7 done" : "R5 done", int'(done), 1);
        chk(status === exp_st, (d >= TO) ? "R7 status" : "R6 status", int'(status), int'(exp_st));
        chk(step_en === 1'b0, "R4 step fall", int'(step_en), 0);
      end else begin
        chk(done === 1'b0 && status === 3'b000, "R8 quiet", int'({done, status}), 0);
        chk(step_en === 1'b1 && drv_tristate === 1'b1, "R10 hold", int'({step_en, drv_tristate}), 3);
      end
    end
    @(negedge clk);
    chk(done === 1'b0 && status === 3'b000, "R8 single pulse", int'({done, status}), 0);
    cmp_level = 1'b0;
    force_idle = 1'b1;
  endtask

  task automatic wait_lead();
    force_idle = 1'b1;
    tick(LEAD + 2);
  endtask

  initial begin
    tick(3);
    chk(step_en === 0 && done === 0 && drv_tristate === 0 && status === 0,
        "R1 reset", int'({step_en, done, drv_tristate, status}), 0);
    // R9: request already high through reset must not start
    det_req = 1'b1; force_idle = 1'b1;
    tick(1);
    rst = 1'b0;
    tick(LEAD + 6);
    chk(step_en === 1'b0, "R9 stale request", int'(step_en), 0);
    det_req = 1'b0; force_idle = 1'b0;
    tick(2);
    chk(drv_tristate === 1'b0, "R10 released", int'(drv_tristate), 0);

    // R3/R10: lead count and drv_tristate following force_idle
    force_idle = 1'b1; det_req = 1'b1;
    for (int n = 1; n <= LEAD + 1; n++) begin
      @(negedge clk);
      if (n == 1) chk(drv_tristate === 1'b1, "R10 follow", int'(drv_tristate), 1);
      if (n <= LEAD) chk(step_en === 1'b0, "R3 lead holdoff", int'(step_en), 0);
    end
    measure(0, 1'b0);
    det_req = 1'b0; tick(2);

    // R3: single-cycle idle drop restarts the lead count
    force_idle = 1'b0; tick(2);
    force_idle = 1'b1; det_req = 1'b1;
    tick(7);
    force_idle = 1'b0; tick(1);
    force_idle = 1'b1;
    for (int n = 1; n <= LEAD + 1; n++) begin
      @(negedge clk);
      if (n <= LEAD) chk(step_en === 1'b0, "R3 restart", int'(step_en), 0);
    end
    measure(THR, 1'b0);
    det_req = 1'b0; tick(2);

    // R2: requests outside P1 are held off, then start on entering P1
    for (int p = 0; p < 4; p++) begin
      if (p == 2) continue;
      pwr_state = 2'(p);
      wait_lead();
      det_req = 1'b1;
      tick(15);
      chk(step_en === 1'b0, "R2 non-P1 holdoff", int'(step_en), 0);
      pwr_state = 2'b10;
      @(negedge clk);
      measure(1, 1'b0);
      det_req = 1'b0; tick(2);
    end

    // R5/R6/R7: sweep of comparator delay across threshold and timeout
    wait_lead();
    for (int d = 0; d <= TO + 2; d++) begin
      det_req = 1'b1;
      @(negedge clk);
      measure(d, (d == 3));
      // R9: holding the request high starts nothing new
      tick(4);
      chk(step_en === 1'b0 && done === 1'b0, "R9 no restart", int'({step_en, done}), 0);
      det_req = 1'b0;
      tick(LEAD + 2);
    end

    ended = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !ended) begin
      ended = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule